// File: doc/BRIEF.md
# SRAM March Test Sequencer

This block is a built-in self-test controller for a synchronous single-port SRAM with one cycle of read latency. A pulse on `start` launches one of two fixed March algorithms over the whole address space. The engine drives the memory's address, write data, write enable and read enable. It checks every read against the value the algorithm expects, and it reports through `busy`, `done` and `fail`.

Both algorithms contain pause elements. During a pause no access is made for a loaded number of cycles, so a cell that leaks its contents is caught by the next read. The longer algorithm also reads the same cell twice in a row. This exposes a cell whose first read returns the right value but disturbs the stored bit. The first miscompare freezes its address, element number and operation number, and the run still completes.

Top module: `mbist_march_engine`

## Requirements
- R1: After reset, and after a reset applied in the middle of a run, `busy`, `done`, `fail`, `mem_we` and `mem_re` are all low.
- R2: When `start` is high at a clock edge while the engine is idle or done, that edge launches a run. From the next cycle `busy` is high and `done` and `fail` are low. A `start` while `busy` is high has no effect on the run.
- R3: With `alg_sel` = 0 the engine runs eight elements, indexed 0 to 7. They are: 0 write 0 to all cells; 1 ascending read 0 then write 1; 2 ascending read 1 then write 0; 3 descending read 0 then write 1; 4 pause; 5 descending read 1, read 1, write 0; 6 pause; 7 read 0 twice per cell. This is 12N accesses.
- R4: With `alg_sel` = 1 the engine runs six elements, indexed 0 to 5. They are: 0 write 0 to all cells; 1 pause; 2 ascending read 0, write 0, write 1, read 1; 3 pause; 4 descending read 1, write 1, write 0, read 0; 5 read 0 of every cell. This is 10N accesses.
- R5: An ascending element visits addresses 0 up to N-1. A descending element visits N-1 down to 0. An element without a direction runs ascending. All operations of an element act on one address before the address moves.
- R6: Data value 0 means all bits low and 1 means all bits high, both for write data and for expected read data.
- R7: A pause element makes no memory access for `hold_len`+1 cycles. `hold_len` is sampled on the launching edge.
- R8: Read data is compared in the cycle after the read is issued. Any bit difference sets `fail`.
- R9: Only the first miscompare is recorded: `fail_addr`, `fail_elem` and `fail_op` (the operation's 0-based position within its element). These values and `fail` stay unchanged until the next launch. The run continues to its end.
- R10: `done` rises a fixed number of edges after the launching edge: accesses + pauses×(`hold_len`+1) + 1. At that point `busy` is low and `fail` covers every read of the run.
- R11: `mem_we` and `mem_re` are never high together, and both are low whenever `busy` is low.
- R12: A cell whose correct first read flips its contents is reported by algorithm 0 at element 5, operation 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse |
| alg_sel | input | 1 | Algorithm choice: 0 long, 1 short |
| hold_len | input | HOLD_W | Pause length control, sampled at launch |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_re` |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished |
| fail | output | 1 | At least one miscompare in this run |
| fail_addr | output | ADDR_W | Address of first miscompare |
| fail_elem | output | 3 | Element index of first miscompare |
| fail_op | output | 2 | Operation index of first miscompare |

## Verification
Both algorithms are run against a bench memory with no fault, with one data bit stuck high, and with one data bit stuck low. The two stuck polarities land in different elements and operations, which separates the read-0 checks from the read-1 checks. A leaking cell is placed at the top and bottom addresses and tried with pause lengths just below and just above the leak threshold. This shows that the pause length really controls the idle window and that descending passes start at the top. A read-flip cell and an aliased address then show what the double read and the ascending order each detect, and the recorded element and operation numbers pin down which access caught each fault.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   localparam int EIDX_W = 3;
   localparam int OIDX_W = 2;

   typedef enum logic [1:0] {OP_R0, OP_R1, OP_W0, OP_W1} op_e;
   typedef enum logic [1:0] {DIR_UP, DIR_DN, DIR_ANY} dir_e;

   typedef struct packed {
      logic              pause;
      logic              final_el;
      dir_e              dir;
      logic [OIDX_W-1:0] n_m1;
      op_e               o0;
      op_e               o1;
      op_e               o2;
      op_e               o3;
   } elem_t;

   function automatic elem_t mk_el(input logic p, input logic f, input dir_e d,
                                   input int n, input op_e a, input op_e b,
                                   input op_e c, input op_e e);
      elem_t r;
      r.pause    = p;
      r.final_el = f;
      r.dir      = d;
      r.n_m1     = OIDX_W'(n - 1);
      r.o0 = a; r.o1 = b; r.o2 = c; r.o3 = e;
      return r;
   endfunction

   // alg 0: long sequence with double reads; alg 1: short sequence
   function automatic elem_t elem_lookup(input logic alg, input logic [EIDX_W-1:0] idx);
      elem_t r;
      r = mk_el(1'b0, 1'b1, DIR_ANY, 1, OP_R0, OP_R0, OP_R0, OP_R0);
      if (!alg) begin
         case (idx)
            3'd0: r = mk_el(1'b0, 1'b0, DIR_ANY, 1, OP_W0, OP_W0, OP_W0, OP_W0);
            3'd1: r = mk_el(1'b0, 1'b0, DIR_UP,  2, OP_R0, OP_W1, OP_W1, OP_W1);
            3'd2: r = mk_el(1'b0, 1'b0, DIR_UP,  2, OP_R1, OP_W0, OP_W0, OP_W0);
            3'd3: r = mk_el(1'b0, 1'b0, DIR_DN,  2, OP_R0, OP_W1, OP_W1, OP_W1);
            3'd4: r = mk_el(1'b1, 1'b0, DIR_ANY, 1, OP_R0, OP_R0, OP_R0, OP_R0);
            3'd5: r = mk_el(1'b0, 1'b0, DIR_DN,  3, OP_R1, OP_R1, OP_W0, OP_W0);
            3'd6: r = mk_el(1'b1, 1'b0, DIR_ANY, 1, OP_R0, OP_R0, OP_R0, OP_R0);
            3'd7: r = mk_el(1'b0, 1'b1, DIR_ANY, 2, OP_R0, OP_R0, OP_R0, OP_R0);
            default: ;
         endcase
      end else begin
         case (idx)
            3'd0: r = mk_el(1'b0, 1'b0, DIR_ANY, 1, OP_W0, OP_W0, OP_W0, OP_W0);
            3'd1: r = mk_el(1'b1, 1'b0, DIR_ANY, 1, OP_R0, OP_R0, OP_R0, OP_R0);
            3'd2: r = mk_el(1'b0, 1'b0, DIR_UP,  4, OP_R0, OP_W0, OP_W1, OP_R1);
            3'd3: r = mk_el(1'b1, 1'b0, DIR_ANY, 1, OP_R0, OP_R0, OP_R0, OP_R0);
            3'd4: r = mk_el(1'b0, 1'b0, DIR_DN,  4, OP_R1, OP_W1, OP_W0, OP_R0);
            3'd5: r = mk_el(1'b0, 1'b1, DIR_ANY, 1, OP_R0, OP_R0, OP_R0, OP_R0);
            default: ;
         endcase
      end
      return r;
   endfunction

   function automatic op_e op_pick(input elem_t e, input logic [OIDX_W-1:0] i);
      case (i)
         2'd0:    return e.o0;
         2'd1:    return e.o1;
         2'd2:    return e.o2;
         default: return e.o3;
      endcase
   endfunction

endpackage

// File: rtl/mbist_addr_seq.sv
module mbist_addr_seq #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              load_down,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              at_end
);
   localparam logic [ADDR_W-1:0] TOP = '1;

   logic              down_q;
   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         down_q <= 1'b0;
         addr_q <= '0;
      end else if (load) begin
         down_q <= load_down;
         addr_q <= load_down ? TOP : '0;
      end else if (step) begin
         addr_q <= down_q ? addr_q - 1'b1 : addr_q + 1'b1;
      end
   end

   assign addr   = addr_q;
   assign at_end = down_q ? (addr_q == '0) : (addr_q == TOP);
endmodule

// File: rtl/mbist_resp_check.sv
module mbist_resp_check #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4,
   parameter int EIDX_W = 3,
   parameter int OIDX_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rd_issue,
   input  logic              exp_one,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [EIDX_W-1:0] rd_elem,
   input  logic [OIDX_W-1:0] rd_op,
   input  logic [DATA_W-1:0] rdata,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [EIDX_W-1:0] fail_elem,
   output logic [OIDX_W-1:0] fail_op
);
   logic              pend_q, exp_q, fail_q;
   logic [ADDR_W-1:0] tag_addr_q, fa_q;
   logic [EIDX_W-1:0] tag_elem_q, fe_q;
   logic [OIDX_W-1:0] tag_op_q, fo_q;
   logic              miscompare;

   assign miscompare = pend_q && (rdata != {DATA_W{exp_q}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0; exp_q <= 1'b0;
         tag_addr_q <= '0; tag_elem_q <= '0; tag_op_q <= '0;
         fail_q <= 1'b0; fa_q <= '0; fe_q <= '0; fo_q <= '0;
      end else begin
         pend_q <= rd_issue && !clear;
         if (rd_issue) begin
            exp_q      <= exp_one;
            tag_addr_q <= rd_addr;
            tag_elem_q <= rd_elem;
            tag_op_q   <= rd_op;
         end
         if (clear) begin
            fail_q <= 1'b0;
         end else if (miscompare && !fail_q) begin
            fail_q <= 1'b1;
            fa_q   <= tag_addr_q;
            fe_q   <= tag_elem_q;
            fo_q   <= tag_op_q;
         end
      end
   end

   assign fail      = fail_q;
   assign fail_addr = fa_q;
   assign fail_elem = fe_q;
   assign fail_op   = fo_q;
endmodule

// File: rtl/mbist_march_engine.sv
module mbist_march_engine
   import mbist_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8,
   parameter int HOLD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              alg_sel,
   input  logic [HOLD_W-1:0] hold_len,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_we,
   output logic              mem_re,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic [ADDR_W-1:0] fail_addr,
   output logic [EIDX_W-1:0] fail_elem,
   output logic [OIDX_W-1:0] fail_op
);
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be at least 1");
   end
   if (HOLD_W < 1) begin : g_bad_hold
      $error("HOLD_W must be at least 1");
   end

   typedef enum logic [2:0] {S_IDLE, S_RUN, S_PAUSE, S_FLUSH, S_DONE} st_e;

   st_e               st_q;
   logic              alg_q;
   logic [HOLD_W-1:0] hold_q, pause_cnt;
   logic [EIDX_W-1:0] elem_q;
   logic [OIDX_W-1:0] op_q;
   elem_t             cur, nxt;
   op_e               cur_op;
   logic              op_last, launch;
   logic              ag_load, ag_down, ag_step, at_end;
   logic [ADDR_W-1:0] addr;

   assign cur     = elem_lookup(alg_q, elem_q);
   assign nxt     = elem_lookup(alg_q, elem_q + 1'b1);
   assign cur_op  = op_pick(cur, op_q);
   assign op_last = (op_q == cur.n_m1);
   assign launch  = start && (st_q == S_IDLE || st_q == S_DONE);

   always_comb begin
      ag_load = 1'b0;
      ag_down = 1'b0;
      ag_step = 1'b0;
      case (st_q)
         S_IDLE, S_DONE: if (start) begin
            ag_load = 1'b1;
            ag_down = (elem_lookup(alg_sel, '0).dir == DIR_DN);
         end
         S_RUN: if (op_last) begin
            if (!at_end) ag_step = 1'b1;
            else if (!cur.final_el && !nxt.pause) begin
               ag_load = 1'b1;
               ag_down = (nxt.dir == DIR_DN);
            end
         end
         S_PAUSE: if (pause_cnt == '0) begin
            ag_load = 1'b1;
            ag_down = (nxt.dir == DIR_DN);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= S_IDLE; alg_q <= 1'b0; hold_q <= '0; pause_cnt <= '0;
         elem_q <= '0; op_q <= '0;
      end else begin
         case (st_q)
            S_IDLE, S_DONE: if (start) begin
               alg_q  <= alg_sel;
               hold_q <= hold_len;
               elem_q <= '0;
               op_q   <= '0;
               st_q   <= S_RUN;
            end
            S_RUN: begin
               if (!op_last) begin
                  op_q <= op_q + 1'b1;
               end else begin
                  op_q <= '0;
                  if (at_end) begin
                     if (cur.final_el) st_q <= S_FLUSH;
                     else begin
                        elem_q <= elem_q + 1'b1;
                        if (nxt.pause) begin
                           st_q      <= S_PAUSE;
                           pause_cnt <= hold_q;
                        end
                     end
                  end
               end
            end
            S_PAUSE: begin
               if (pause_cnt == '0) begin
                  elem_q <= elem_q + 1'b1;
                  st_q   <= S_RUN;
               end else begin
                  pause_cnt <= pause_cnt - 1'b1;
               end
            end
            S_FLUSH: st_q <= S_DONE;
            default: st_q <= S_IDLE;
         endcase
      end
   end

   mbist_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .load(ag_load), .load_down(ag_down),
      .step(ag_step), .addr(addr), .at_end(at_end)
   );

   assign mem_addr  = addr;
   assign mem_we    = (st_q == S_RUN) && (cur_op == OP_W0 || cur_op == OP_W1);
   assign mem_re    = (st_q == S_RUN) && (cur_op == OP_R0 || cur_op == OP_R1);
   assign mem_wdata = {DATA_W{cur_op == OP_W1}};
   assign busy      = (st_q == S_RUN) || (st_q == S_PAUSE) || (st_q == S_FLUSH);
   assign done      = (st_q == S_DONE);

   mbist_resp_check #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .EIDX_W(EIDX_W), .OIDX_W(OIDX_W)) u_cmp (
      .clk(clk), .rst_n(rst_n), .clear(launch), .rd_issue(mem_re),
      .exp_one(cur_op == OP_R1), .rd_addr(addr), .rd_elem(elem_q), .rd_op(op_q),
      .rdata(mem_rdata), .fail(fail), .fail_addr(fail_addr),
      .fail_elem(fail_elem), .fail_op(fail_op)
   );
endmodule

// File: rtl/mbist_march_engine_chk.sv
module mbist_march_engine_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              mem_we,
   input logic              mem_re,
   input logic [ADDR_W-1:0] fail_addr,
   input logic [2:0]        fail_elem,
   input logic [1:0]        fail_op
);
   p_rw_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   p_quiet_when_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !mem_re));

   p_done_excl_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));

   p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done && !fail));

   p_fail_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !(start && !busy)) |=> fail);

   p_fail_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !(start && !busy)) |=>
         ($stable(fail_addr) && $stable(fail_elem) && $stable(fail_op)));
endmodule

bind mbist_march_engine mbist_march_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
   .fail(fail), .mem_we(mem_we), .mem_re(mem_re), .fail_addr(fail_addr),
   .fail_elem(fail_elem), .fail_op(fail_op)
);

// File: tb/mbist_march_engine_bench.sv
module mbist_march_engine_bench;
   localparam int AW = 4;
   localparam int DW = 8;
   localparam int HW = 8;
   localparam int NC = 1 << AW;
   localparam int RET = 3;   // idle cycles after which a leaking cell empties

   typedef struct packed {
      logic        alg;
      logic [7:0]  hold;
      logic [2:0]  ft;   // 0 none, 1 stuck bit, 2 leak, 3 read flip, 4 alias fa->fb
      logic [3:0]  fa;
      logic [3:0]  fb;
      logic        sv;
      logic        xf;
      logic [3:0]  xa;
      logic [2:0]  xe;
      logic [1:0]  xo;
      logic [15:0] xc;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'd5, 3'd0, 4'd0,  4'd0, 1'b0, 1'b0, 4'd0,  3'd0, 2'd0, 16'd205},
      '{1'b0, 8'd4, 3'd1, 4'd5,  4'd2, 1'b1, 1'b1, 4'd5,  3'd1, 2'd0, 16'd203},
      '{1'b1, 8'd4, 3'd1, 4'd5,  4'd2, 1'b1, 1'b1, 4'd5,  3'd2, 2'd0, 16'd171},
      '{1'b0, 8'd4, 3'd1, 4'd5,  4'd2, 1'b0, 1'b1, 4'd5,  3'd2, 2'd0, 16'd203},
      '{1'b1, 8'd4, 3'd1, 4'd5,  4'd2, 1'b0, 1'b1, 4'd5,  3'd2, 2'd3, 16'd171},
      '{1'b1, 8'd5, 3'd0, 4'd0,  4'd0, 1'b0, 1'b0, 4'd0,  3'd0, 2'd0, 16'd173},
      '{1'b0, 8'd6, 3'd2, 4'd15, 4'd0, 1'b0, 1'b1, 4'd15, 3'd5, 2'd0, 16'd207},
      '{1'b1, 8'd6, 3'd2, 4'd0,  4'd0, 1'b0, 1'b1, 4'd0,  3'd4, 2'd0, 16'd175},
      '{1'b0, 8'd1, 3'd2, 4'd7,  4'd0, 1'b0, 1'b0, 4'd0,  3'd0, 2'd0, 16'd197},
      '{1'b0, 8'd2, 3'd2, 4'd7,  4'd0, 1'b0, 1'b1, 4'd7,  3'd5, 2'd0, 16'd199},
      '{1'b0, 8'd3, 3'd3, 4'd8,  4'd0, 1'b0, 1'b1, 4'd8,  3'd5, 2'd1, 16'd201}, // R12
      '{1'b0, 8'd3, 3'd4, 4'd3,  4'd9, 1'b0, 1'b1, 4'd9,  3'd1, 2'd0, 16'd201},
      '{1'b1, 8'd3, 3'd4, 4'd3,  4'd9, 1'b0, 1'b1, 4'd9,  3'd2, 2'd0, 16'd169},
      '{1'b0, 8'd0, 3'd0, 4'd0,  4'd0, 1'b0, 1'b0, 4'd0,  3'd0, 2'd0, 16'd195}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          alg_sel = 1'b0;
   logic [HW-1:0] hold_len = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we, mem_re;
   logic [DW-1:0] mem_rdata = '0;
   logic          busy, done, fail;
   logic [AW-1:0] fail_addr;
   logic [2:0]    fail_elem;
   logic [1:0]    fail_op;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   logic [2:0]    f_type = '0;
   logic [3:0]    f_a = '0, f_b = '0;
   logic          f_v = 1'b0;
   logic [DW-1:0] mem [NC];
   int            idle_run = 0;

   always #5 clk = ~clk;

   mbist_march_engine #(.ADDR_W(AW), .DATA_W(DW), .HOLD_W(HW)) u_mbist_march_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .alg_sel(alg_sel), .hold_len(hold_len),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail),
      .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_op(fail_op)
   );

   initial for (int i = 0; i < NC; i++) mem[i] = '0;

   // faulty single-port memory model, one cycle read latency
   always @(posedge clk) begin : mem_model
      logic [AW-1:0] pa;
      logic [DW-1:0] v;
      pa = (f_type == 3'd4 && mem_addr == f_a) ? f_b : mem_addr;
      if (mem_we) begin
         v = mem_wdata;
         if (f_type == 3'd1 && pa == f_a) v[f_b[2:0]] = f_v;
         mem[pa] = v;
      end
      if (mem_re) begin
         mem_rdata <= mem[pa];
         if (f_type == 3'd3 && pa == f_a) mem[pa] = ~mem[pa];
      end
      if (!mem_we && !mem_re) idle_run = idle_run + 1;
      else idle_run = 0;
      if (f_type == 3'd2 && idle_run == RET) mem[f_a] = '0;
   end

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
         finish_run();
      end
   end

   task automatic run_vec(input vec_t v);
      int ncy, nacc, nidle, novl;
      int a80, a2nd, w81;
      int second_idx;
      string tg;
      second_idx = v.alg ? 84 : 82;
      tg = v.alg ? "R4" : "R3";
      @(negedge clk);
      f_type = v.ft; f_a = v.fa; f_b = v.fb; f_v = v.sv;
      alg_sel = v.alg; hold_len = v.hold; start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after launch", busy, 1);
      check("R2 fail cleared at launch", fail, 0);
      ncy = 0; nacc = 0; nidle = 0; novl = 0; a80 = -1; a2nd = -1; w81 = -1;
      while (!done && ncy < 5000) begin
         start = (ncy == 50);   // launch attempt while busy: must be ignored (R2)
         if (mem_we && mem_re) novl++;
         if (busy && !mem_we && !mem_re) nidle++;
         if (mem_we || mem_re) begin
            if (nacc == 80) a80 = int'(mem_addr);
            if (nacc == 81) w81 = int'(mem_wdata);
            if (nacc == second_idx) a2nd = int'(mem_addr);
            nacc++;
         end
         @(posedge clk);
         @(negedge clk);
         ncy++;
      end
      start = 1'b0;
      check("R10 launch-to-done edges (R2 start ignored while busy)", ncy, int'(v.xc));
      check({tg, " access count"}, nacc, v.alg ? 10 * NC : 12 * NC);
      check("R7 idle cycles while busy", nidle, 2 * (int'(v.hold) + 1) + 1);
      check("R11 read/write overlap cycles", novl, 0);
      check("R10 busy low at done", busy, 0);
      check("R5 descending element starts at top", a80, NC - 1);
      check("R5 descending second address", a2nd, NC - 2);
      check("R6 write-1 data all ones", w81, (1 << DW) - 1);
      check("R8 fail flag", fail, int'(v.xf));
      if (v.xf) begin
         check("R9 first fail address", fail_addr, int'(v.xa));
         check("R9 first fail element", fail_elem, int'(v.xe));
         check("R9 first fail operation", fail_op, int'(v.xo));
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 busy at reset", busy, 0);
      check("R1 done at reset", done, 0);
      check("R1 fail at reset", fail, 0);
      check("R1 we at reset", mem_we, 0);
      check("R1 re at reset", mem_re, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 idle after reset release", busy, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // reset in the middle of a run (R1)
      @(negedge clk);
      f_type = '0; alg_sel = 1'b0; hold_len = 8'd5; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (30) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 busy after mid-run reset", busy, 0);
      check("R1 we after mid-run reset", mem_we, 0);
      check("R1 re after mid-run reset", mem_re, 0);
      check("R1 done after mid-run reset", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_vec(VECS[0]);

      finish_run();
   end
endmodule